// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a configuration unit that a host reaches through two adjacent I/O addresses. The lower address is the index port and names a register. The address above it is the data port and reads or writes that register. At first the unit is locked. A fixed key byte written to the index port on two consecutive index writes opens it. A second key byte written to the index port closes it again. A strap input, captured while reset is held, selects one of two index port addresses.

Once the unit is open, the index reaches a small set of global registers: a device selector, a soft-reset control, and a read-only identity and revision. Any index at or above 30h reaches the register bank of the logical device chosen by the selector. Each bank holds an enable bit, a 16-bit I/O base aligned to 8 bytes, an interrupt line number and a DMA channel choice. Every bank drives its settings onto its own output pins, which the surrounding function blocks use.

Top module: `cfgp_port`

## Requirements
- R1: After reset the port is locked. Every device is inactive, with base 0000h, IRQ 0 and DMA select 4 (no DMA).
- R2: The port unlocks only when 87h is written to the index port on two consecutive index writes. Any other index write in between restarts the count.
- R3: The index port is at 2Eh when the strap was low during reset and at 4Eh when it was high. The data port is the index address plus one. Reads of any other address return 00h, and writes to any other address have no effect.
- R4: While the port is locked, reads of the data port and of the index port return FFh, and data port writes have no effect. While it is unlocked, an index port read returns the current index.
- R5: Writing AAh to the index port while unlocked locks the port again. The AAh is not stored, so the index keeps its previous value.
- R6: Register 07h holds the device number and is readable and writable. Indexes 30h and above reach the bank of that device. If the device number is NUM_DEV or higher, bank reads return 00h and bank writes have no effect.
- R7: Register 20h reads back the DEV_ID parameter and register 21h reads back DEV_REV. Writes to either have no effect.
- R8: Bit 0 of bank register 30h is the device's active flag. Bits 7:1 read back as 0.
- R9: Bank registers 60h and 61h are the high and low bytes of the I/O base. Bits 2:0 of the low byte always read as 0, and the output base carries the same value.
- R10: Bits 3:0 of bank register 70h are the IRQ number. Bits 7:4 read as 0.
- R11: Bits 2:0 of bank register 74h select the DMA channel. Values 0 to 3 drive that channel with the enable set. Values 4 to 7 clear the enable. Bits 7:3 read as 0.
- R12: Writing 02h with bit 0 set returns every bank and the device number to their reset values on the next cycle. The port stays unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt_i | input | 1 | Address strap, sampled while reset is held |
| io_addr_i | input | ADDR_W | I/O address of the current access |
| io_wr_i | input | 1 | Write strobe, one cycle per write |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid in the cycle the read strobe is high |
| unlocked_o | output | 1 | High while configuration access is open |
| dev_active_o | output | NUM_DEV | Active flag of each device |
| dev_base_o | output | NUM_DEV*16 | I/O base of each device, device d at bits d*16 +: 16 |
| dev_irq_o | output | NUM_DEV*4 | IRQ number of each device |
| dev_dma_ch_o | output | NUM_DEV*2 | DMA channel of each device |
| dev_dma_en_o | output | NUM_DEV | DMA enable of each device |

## Verification
The key sequence is driven several ways. A clean double key must unlock. A key, then a foreign byte, then a key must stay half-way and still read FFh, which separates "two in a row" from "two in total". A relock followed by a data write shows that writes are blocked while locked and that the index is kept across the relock. Each device bank is loaded with a distinct pattern that also sets reserved bits. This exposes any crosstalk between banks, any missing masking of reserved bits, and the boundary between DMA values 3 and 7. An out-of-range device number, a write to the other strap address, a soft reset, and a second reset with the strap high cover the decode and the restore paths.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  localparam logic [7:0] IX_SRST = 8'h02;
  localparam logic [7:0] IX_LDN  = 8'h07;
  localparam logic [7:0] IX_ID   = 8'h20;
  localparam logic [7:0] IX_REV  = 8'h21;
  localparam logic [7:0] IX_ACT  = 8'h30;
  localparam logic [7:0] IX_BHI  = 8'h60;
  localparam logic [7:0] IX_BLO  = 8'h61;
  localparam logic [7:0] IX_IRQ  = 8'h70;
  localparam logic [7:0] IX_DMA  = 8'h74;

  localparam logic [2:0] DMA_NONE = 3'd4;

  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_t;

  // values 0..3 name a channel, 4..7 mean none
  function automatic logic dma_on(input logic [2:0] sel);
    return ~sel[2];
  endfunction

  function automatic logic is_bank_ix(input logic [7:0] ix);
    return ix >= IX_ACT;
  endfunction
endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr_i,
  input  logic [7:0] idx_data_i,
  output logic       unlocked_o
);
  lock_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        LK_SHUT: state_d = (idx_data_i == KEY_OPEN) ? LK_HALF : LK_SHUT;
        LK_HALF: state_d = (idx_data_i == KEY_OPEN) ? LK_OPEN : LK_SHUT;
        LK_OPEN: state_d = (idx_data_i == KEY_CLOSE) ? LK_SHUT : LK_OPEN;
        default: state_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_SHUT;
    else        state_q <= state_d;
  end

  assign unlocked_o = (state_q == LK_OPEN);

  // R2: opening is always caused by a key write in the previous cycle
  a_r2_open_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(idx_wr_i && idx_data_i == KEY_OPEN));

  // R5: close key while open locks on the next cycle
  a_r5_close_key: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked_o && idx_wr_i && idx_data_i == KEY_CLOSE) |=> !unlocked_o);
endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst_i,
  input  logic        wr_i,
  input  logic [7:0]  ix_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        active_o,
  output logic [15:0] base_o,
  output logic [3:0]  irq_o,
  output logic [2:0]  dma_sel_o
);
  logic       act_q;
  logic [7:0] bhi_q;
  logic [4:0] blo_q;
  logic [3:0] irq_q;
  logic [2:0] dma_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; bhi_q <= '0; blo_q <= '0; irq_q <= '0; dma_q <= DMA_NONE;
    end else if (soft_rst_i) begin
      act_q <= 1'b0; bhi_q <= '0; blo_q <= '0; irq_q <= '0; dma_q <= DMA_NONE;
    end else if (wr_i) begin
      case (ix_i)
        IX_ACT:  act_q <= wdata_i[0];
        IX_BHI:  bhi_q <= wdata_i;
        IX_BLO:  blo_q <= wdata_i[7:3];
        IX_IRQ:  irq_q <= wdata_i[3:0];
        IX_DMA:  dma_q <= wdata_i[2:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ix_i)
      IX_ACT:  rdata_o = {7'd0, act_q};
      IX_BHI:  rdata_o = bhi_q;
      IX_BLO:  rdata_o = {blo_q, 3'd0};
      IX_IRQ:  rdata_o = {4'd0, irq_q};
      IX_DMA:  rdata_o = {5'd0, dma_q};
      default: rdata_o = 8'h00;
    endcase
  end

  assign active_o  = act_q;
  assign base_o    = {bhi_q, blo_q, 3'd0};
  assign irq_o     = irq_q;
  assign dma_sel_o = dma_q;

  // R4/R6: settings move only on a qualified write or a soft reset
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !soft_rst_i) |=> $stable({active_o, base_o, irq_o, dma_sel_o}));

  // R12: soft reset restores defaults
  a_r12_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!active_o && base_o == 16'h0 && irq_o == 4'h0 && dma_sel_o == DMA_NONE));
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
  import cfgp_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_DEV  = 4,
  parameter logic [ADDR_W-1:0] IDX_LO = 'h2E,
  parameter logic [ADDR_W-1:0] IDX_HI = 'h4E,
  parameter logic [7:0] DEV_ID  = 8'h68,
  parameter logic [7:0] DEV_REV = 8'h12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_alt_i,
  input  logic [ADDR_W-1:0]     io_addr_i,
  input  logic                  io_wr_i,
  input  logic                  io_rd_i,
  input  logic [7:0]            io_wdata_i,
  output logic [7:0]            io_rdata_o,
  output logic                  unlocked_o,
  output logic [NUM_DEV-1:0]    dev_active_o,
  output logic [NUM_DEV*16-1:0] dev_base_o,
  output logic [NUM_DEV*4-1:0]  dev_irq_o,
  output logic [NUM_DEV*2-1:0]  dev_dma_ch_o,
  output logic [NUM_DEV-1:0]    dev_dma_en_o
);
  logic              alt_q;
  logic [7:0]        index_q, ldn_q;
  logic [ADDR_W-1:0] idx_addr, dat_addr;
  logic              idx_hit, dat_hit, idx_wr, dat_wr, soft_rst, ldn_ok;
  logic [7:0]        bank_rd [NUM_DEV];
  logic [7:0]        sel_rd;
  logic [NUM_DEV-1:0] bank_wr;

  // strap captured while reset is asserted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alt_q <= strap_alt_i;
    else        alt_q <= alt_q;
  end

  assign idx_addr = alt_q ? IDX_HI : IDX_LO;
  assign dat_addr = idx_addr + ADDR_W'(1);
  assign idx_hit  = (io_addr_i == idx_addr);
  assign dat_hit  = (io_addr_i == dat_addr);
  assign idx_wr   = io_wr_i && idx_hit;
  assign dat_wr   = io_wr_i && dat_hit && unlocked_o;
  assign soft_rst = dat_wr && index_q == IX_SRST && io_wdata_i[0];

  cfgp_key_fsm u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr_i   (idx_wr),
    .idx_data_i (io_wdata_i),
    .unlocked_o (unlocked_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr && unlocked_o && io_wdata_i != KEY_CLOSE) index_q <= io_wdata_i;
      if (soft_rst)                                 ldn_q <= '0;
      else if (dat_wr && index_q == IX_LDN)         ldn_q <= io_wdata_i;
    end
  end

  assign ldn_ok = (ldn_q < 8'(NUM_DEV));

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    logic [2:0] dsel;
    assign bank_wr[d] = dat_wr && is_bank_ix(index_q) && (ldn_q == 8'(d));

    cfgp_dev_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst_i (soft_rst),
      .wr_i       (bank_wr[d]),
      .ix_i       (index_q),
      .wdata_i    (io_wdata_i),
      .rdata_o    (bank_rd[d]),
      .active_o   (dev_active_o[d]),
      .base_o     (dev_base_o[d*16 +: 16]),
      .irq_o      (dev_irq_o[d*4 +: 4]),
      .dma_sel_o  (dsel)
    );

    assign dev_dma_ch_o[d*2 +: 2] = dsel[1:0];
    assign dev_dma_en_o[d]        = dma_on(dsel);
  end

  always_comb begin
    sel_rd = 8'h00;
    for (int d = 0; d < NUM_DEV; d++)
      if (ldn_q == 8'(d)) sel_rd = bank_rd[d];
  end

  always_comb begin
    io_rdata_o = 8'h00;
    if (io_rd_i && idx_hit) begin
      io_rdata_o = unlocked_o ? index_q : 8'hFF;
    end else if (io_rd_i && dat_hit) begin
      if (!unlocked_o) io_rdata_o = 8'hFF;
      else begin
        case (index_q)
          IX_LDN:  io_rdata_o = ldn_q;
          IX_ID:   io_rdata_o = DEV_ID;
          IX_REV:  io_rdata_o = DEV_REV;
          default: io_rdata_o = (is_bank_ix(index_q) && ldn_ok) ? sel_rd : 8'h00;
        endcase
      end
    end
  end

  // R4: locked data port reads return all ones
  a_r4_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_i && dat_hit && !unlocked_o) |-> io_rdata_o == 8'hFF);

  // R6: no bank write is issued for an out-of-range device number
  a_r6_no_wr_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    !ldn_ok |-> bank_wr == '0);

  // R12: soft reset keeps the port open and clears the selector
  a_r12_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (unlocked_o && ldn_q == 8'h00));

  // R3: a write away from both ports leaves lock state unchanged
  a_r3_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_i && !idx_hit && !dat_hit) |=> $stable(unlocked_o));
endmodule

// File: tb/tb_cfgp_port.sv
module tb_cfgp_port;
  localparam int NDEV = 4;
  localparam logic [7:0] ID = 8'h68, REV = 8'h12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic [15:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic unlocked;
  logic [NDEV-1:0] act, dma_en;
  logic [NDEV*16-1:0] base;
  logic [NDEV*4-1:0] irq;
  logic [NDEV*2-1:0] dma_ch;

  int checks = 0, fails = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [15:0] ip, dp;

  always #5 clk = ~clk;

  cfgp_port #(.NUM_DEV(NDEV), .DEV_ID(ID), .DEV_REV(REV)) dut (
    .clk(clk), .rst_n(rst_n), .strap_alt_i(strap), .io_addr_i(addr),
    .io_wr_i(wr), .io_rd_i(rd), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .unlocked_o(unlocked), .dev_active_o(act), .dev_base_o(base),
    .dev_irq_o(irq), .dev_dma_ch_o(dma_ch), .dev_dma_en_o(dma_en));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_io(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  // driver: push expectation, raise strobe for one cycle
  task automatic rd_io(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr_io(ip, ix); wr_io(dp, d);
  endtask

  task automatic reg_rd(input logic [7:0] ix, input logic [7:0] e, input string tag);
    wr_io(ip, ix); rd_io(dp, e, tag);
  endtask

  // monitor: compare read data after the edge in the strobe cycle
  always begin
    @(posedge clk); #2;
    if (rd) begin
      if (exp_q.size() == 0) chk("monitor: read with empty queue", 1, 0);
      else chk(tag_q.pop_front(), {24'd0, rdata}, {24'd0, exp_q.pop_front()});
    end
  end

  function automatic logic [7:0] base_lo_val(input int d); return 8'((d << 4) | 8'h0F); endfunction
  function automatic logic [7:0] dma_val(input int d); return (d == 3) ? 8'hFF : 8'(d | 8'hF8); endfunction

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    ip = s ? 16'h004E : 16'h002E; dp = ip + 16'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    // R1 reset state
    chk("R1 locked", {31'd0, unlocked}, 0);
    chk("R1 active", {28'd0, act}, 0);
    chk("R1 base", base[31:0], 0);
    chk("R1 irq", {16'd0, irq}, 0);
    chk("R1 dma_en", {28'd0, dma_en}, 0);
    rd_io(dp, 8'hFF, "R4 locked data read");
    rd_io(ip, 8'hFF, "R4 locked index read");

    // R2 interrupted key sequence
    wr_io(ip, 8'h87); wr_io(ip, 8'h11); wr_io(ip, 8'h87);
    @(negedge clk); chk("R2 interrupted stays locked", {31'd0, unlocked}, 0);
    rd_io(dp, 8'hFF, "R2 half-way still FF");
    wr_io(ip, 8'h87);
    @(negedge clk); chk("R2 second key unlocks", {31'd0, unlocked}, 1);

    // R7 identity
    reg_rd(8'h20, ID, "R7 device id");
    wr_io(dp, 8'h55);
    rd_io(dp, ID, "R7 id after write");
    reg_rd(8'h21, REV, "R7 revision");
    rd_io(ip, 8'h21, "R4 index readback unlocked");

    // R5 / R4 relock, blocked write, index kept
    reg_wr(8'h07, 8'h02);
    wr_io(ip, 8'hAA);
    @(negedge clk); chk("R5 relocked", {31'd0, unlocked}, 0);
    rd_io(dp, 8'hFF, "R5 data FF after relock");
    wr_io(dp, 8'h03);
    wr_io(ip, 8'h87); wr_io(ip, 8'h87);
    rd_io(dp, 8'h02, "R4 locked write ignored, R5 index kept");

    // R6 R8 R9 R10 R11 per-device programming
    for (int d = 0; d < NDEV; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_wr(8'h30, 8'hFF);
      reg_wr(8'h60, 8'(8'h10 + d));
      reg_wr(8'h61, base_lo_val(d));
      reg_wr(8'h70, 8'(8'hF0 | (d + 5)));
      reg_wr(8'h74, dma_val(d));
    end
    for (int d = 0; d < NDEV; d++) begin
      reg_wr(8'h07, 8'(d));
      reg_rd(8'h30, 8'h01, "R8 active readback");
      reg_rd(8'h60, 8'(8'h10 + d), "R9 base high");
      reg_rd(8'h61, base_lo_val(d) & 8'hF8, "R9 base low masked");
      reg_rd(8'h70, 8'(d + 5), "R10 irq masked");
      reg_rd(8'h74, dma_val(d) & 8'h07, "R11 dma masked");
    end
    @(negedge clk);
    for (int d = 0; d < NDEV; d++) begin
      chk("R8 active pin", {31'd0, act[d]}, 1);
      chk("R9 base pin", {16'd0, base[d*16 +: 16]}, {16'd0, 8'(8'h10 + d), base_lo_val(d) & 8'hF8});
      chk("R10 irq pin", {28'd0, irq[d*4 +: 4]}, 32'(d + 5));
      chk("R11 dma enable", {31'd0, dma_en[d]}, (d == 3) ? 0 : 1);
      if (d != 3) chk("R11 dma channel", {30'd0, dma_ch[d*2 +: 2]}, 32'(d));
    end

    // R6 out-of-range device
    reg_wr(8'h07, 8'h05);
    reg_rd(8'h07, 8'h05, "R6 device number readback");
    reg_wr(8'h30, 8'h00);
    reg_rd(8'h60, 8'h00, "R6 out-of-range read");
    @(negedge clk); chk("R6 out-of-range write ignored", {28'd0, act}, 32'hF);

    // R3 foreign address ignored
    wr_io(16'h004E, 8'hAA);
    wr_io(16'h004F, 8'h00);
    @(negedge clk); chk("R3 other address no relock", {31'd0, unlocked}, 1);
    rd_io(16'h004F, 8'h00, "R3 other address reads 00");
    reg_rd(8'h07, 8'h05, "R3 selector untouched");

    // R12 soft reset
    reg_wr(8'h02, 8'h01);
    @(negedge clk);
    chk("R12 active cleared", {28'd0, act}, 0);
    chk("R12 base cleared", base[63:32], 0);
    chk("R12 dma disabled", {28'd0, dma_en}, 0);
    chk("R12 still unlocked", {31'd0, unlocked}, 1);
    reg_rd(8'h07, 8'h00, "R12 selector cleared");

    // R3 strap high moves the ports
    do_reset(1'b1);
    wr_io(16'h002E, 8'h87); wr_io(16'h002E, 8'h87);
    @(negedge clk); chk("R3 old address no unlock", {31'd0, unlocked}, 0);
    wr_io(ip, 8'h87); wr_io(ip, 8'h87);
    @(negedge clk); chk("R3 alt address unlocks", {31'd0, unlocked}, 1);
    reg_rd(8'h20, ID, "R3 alt data port id");
    rd_io(16'h002F, 8'h00, "R3 old data port reads 00");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule